// File: doc/BRIEF.md
# Tagged Pair-Store Execute Unit

This unit is the execute stage for one store instruction. The instruction writes two 64-bit general registers to memory as one 128-bit beat. The same store also sets the memory tag of the 16-byte granule it lands in. Each cycle the unit takes a 32-bit instruction word and decodes it. It names the three general registers it needs on a small read port. It then forms the access address from either a general register or the stack pointer, plus an immediate scaled by the tag granule.

One clock edge after issue, the unit does one of two things. It may present a single store request that carries the address, the data and the tag. With that request it may also present a base-register writeback. Otherwise it reports exactly one exception: an undefined instruction, a stack-pointer misalignment, or a misaligned granule address.

There are three addressing forms. Post-indexed accesses the base as it is and then advances it. Pre-indexed advances the base first, accesses the new address and keeps it. Plain offset accesses base plus offset and leaves the base unchanged. The tag written with the store is the logical tag held in the upper bits of the access address.

Top module: `tagpair_store_unit`

## Requirements
- R1: An instruction word matches only when bits 31:25 are 0110100, bit 22 is 0 and bits 24:23 are 01 (post-indexed), 11 (pre-indexed) or 10 (plain offset). Any other word, or any cycle with issue low, produces no store, no writeback and no exception in the following cycle.
- R2: The register indices on the read port come straight from the instruction. The base index is bits 9:5, the first data register is bits 4:0 and the second data register is bits 14:10.
- R3: The offset is the 7-bit field in bits 21:15, taken as a signed value and multiplied by the granule size (16 bytes by default).
- R4: When the feature-enable input is low, a matching instruction raises the undefined-instruction output and performs no store and no writeback. This exception takes priority over every fault.
- R5: A base index of 31 selects the stack pointer as the base, and any other index selects the general register read on the port. With base 31, alignment-check enable high and stack-pointer bits 3:0 not all zero, the stack-pointer fault output is raised and the store and writeback are suppressed. This fault takes priority over the granule fault.
- R6: The access address is base plus offset for the pre-indexed and plain-offset forms. It is the unmodified base for the post-indexed form.
- R7: When the access address bits 3:0 are not all zero, the granule-alignment fault is raised and the store and writeback are suppressed. A store is never issued to a misaligned address, and at most one of store, undefined, stack-pointer fault and granule fault is active in a cycle.
- R8: When the big-endian input is high, the 128-bit store data holds the first data register in bits 127:64 and the second in bits 63:0. When it is low, the two halves swap places.
- R9: The 4-bit tag sent with the store equals bits 59:56 of the access address.
- R10: The post- and pre-indexed forms write base plus offset back. The writeback goes to the stack pointer (with the sp flag set and index 31) when the base index is 31, and otherwise to the general register the base index names. The plain-offset form writes nothing back. A writeback occurs only together with a store.
- R11: All outputs except the read-port indices are registered. They appear one cycle after issue, last one cycle, and are zero during reset. Address, data, tag and writeback fields read zero whenever their valid bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| feat_en | input | 1 | Tagging feature enabled |
| big_endian | input | 1 | Data endianness for this access |
| sp_align_en | input | 1 | Stack-pointer alignment check enable |
| sp_val | input | 64 | Current stack pointer |
| rf_idx_base | output | 5 | Read-port index for the base register |
| rf_idx_t1 | output | 5 | Read-port index for the first data register |
| rf_idx_t2 | output | 5 | Read-port index for the second data register |
| rf_base | input | 64 | Value read at rf_idx_base |
| rf_t1 | input | 64 | Value read at rf_idx_t1 |
| rf_t2 | input | 64 | Value read at rf_idx_t2 |
| st_valid | output | 1 | Store request |
| st_addr | output | 64 | Store address |
| st_data | output | 128 | Store data |
| st_tag | output | 4 | Allocation tag for the granule |
| wb_valid | output | 1 | Base writeback request |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Writeback value |
| exc_undef | output | 1 | Undefined-instruction exception |
| exc_sp_align | output | 1 | Stack-pointer alignment fault |
| exc_align | output | 1 | Granule alignment fault |

## Verification
The bench builds the unit with its default parameters: a 16-byte granule (shift of 4) and a 4-bit tag at address bit 56. With these values, small bases and offsets reach every low-nibble alignment case directly. The full 7-bit immediate range reaches a largest offset of +1008 and a smallest of -1024 bytes. A base with distinct upper-byte patterns shows that the tag is taken from the access address and not from the base. Stack-pointer cases with the check on and off show the priority order between the two alignment faults.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int XLEN      = 64;
    localparam int INSTR_W   = 32;
    localparam int IDX_W     = 5;
    localparam int IMM_W     = 7;
    localparam int SP_IDX    = 31;
    localparam logic [6:0] OPC_HI = 7'b0110100;

    typedef enum logic [1:0] {
        FORM_NONE = 2'b00,
        FORM_POST = 2'b01,
        FORM_SOFF = 2'b10,
        FORM_PRE  = 2'b11
    } form_e;

    typedef struct packed {
        logic              match;
        form_e             form;
        logic [IMM_W-1:0]  simm;
        logic [IDX_W-1:0]  rn;
        logic [IDX_W-1:0]  rt;
        logic [IDX_W-1:0]  rt2;
    } dec_t;

    typedef struct packed {
        logic              st_valid;
        logic [XLEN-1:0]   st_addr;
        logic [2*XLEN-1:0] st_data;
        logic              wb_valid;
        logic              wb_to_sp;
        logic [IDX_W-1:0]  wb_idx;
        logic [XLEN-1:0]   wb_data;
        logic              exc_undef;
        logic              exc_sp_align;
        logic              exc_align;
    } result_t;

    function automatic dec_t f_decode(input logic [INSTR_W-1:0] w);
        dec_t d;
        d.simm  = w[21:15];
        d.rt2   = w[14:10];
        d.rn    = w[9:5];
        d.rt    = w[4:0];
        d.form  = form_e'(w[24:23]);
        d.match = (w[31:25] == OPC_HI) && !w[22] && (w[24:23] != 2'b00);
        return d;
    endfunction

    function automatic logic [XLEN-1:0] f_scale_imm(input logic [IMM_W-1:0] imm,
                                                    input int unsigned   sh);
        logic [XLEN-1:0] ext;
        ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        return ext << sh;
    endfunction

endpackage

// File: rtl/tps_decode.sv
module tps_decode
    import tps_pkg::*;
(
    input  logic                 issue_valid,
    input  logic [INSTR_W-1:0]   instr,
    output dec_t                 dec,
    output logic                 taken
);
    always_comb begin
        dec   = f_decode(instr);
        taken = issue_valid && dec.match;
    end
endmodule

// File: rtl/tps_agen.sv
module tps_agen
    import tps_pkg::*;
#(
    parameter int GRAN_LOG2 = 4
) (
    input  form_e              form,
    input  logic [IMM_W-1:0]   simm,
    input  logic               base_is_sp,
    input  logic [XLEN-1:0]    gpr_base,
    input  logic [XLEN-1:0]    sp_val,
    input  logic               sp_align_en,
    output logic [XLEN-1:0]    acc_addr,
    output logic [XLEN-1:0]    next_base,
    output logic               sp_fault,
    output logic               gran_fault
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] moved;

    always_comb begin
        base      = base_is_sp ? sp_val : gpr_base;
        offset    = f_scale_imm(simm, GRAN_LOG2);
        moved     = base + offset;
        acc_addr  = (form == FORM_POST) ? base : moved;
        next_base = moved;
        sp_fault  = base_is_sp && sp_align_en && (|sp_val[GRAN_LOG2-1:0]);
        gran_fault = |acc_addr[GRAN_LOG2-1:0];
    end
endmodule

// File: rtl/tps_pack.sv
module tps_pack
    import tps_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic [XLEN-1:0]    xt1,
    input  logic [XLEN-1:0]    xt2,
    input  logic               big_endian,
    input  logic [TAG_W-1:0]   tag_src,
    output logic [2*XLEN-1:0]  data,
    output logic [TAG_W-1:0]   tag
);
    // half 0 = bits 63:0, half 1 = bits 127:64
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic use_t1;
        assign use_t1 = (h == 1) ? big_endian : !big_endian;
        assign data[h*XLEN +: XLEN] = use_t1 ? xt1 : xt2;
    end
    assign tag = tag_src;
endmodule

// File: rtl/tagpair_store_unit.sv
module tagpair_store_unit
    import tps_pkg::*;
#(
    parameter int GRAN_LOG2 = 4,
    parameter int TAG_LSB   = 56,
    parameter int TAG_W     = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_valid,
    input  logic [31:0]        instr,
    input  logic               feat_en,
    input  logic               big_endian,
    input  logic               sp_align_en,
    input  logic [63:0]        sp_val,
    output logic [4:0]         rf_idx_base,
    output logic [4:0]         rf_idx_t1,
    output logic [4:0]         rf_idx_t2,
    input  logic [63:0]        rf_base,
    input  logic [63:0]        rf_t1,
    input  logic [63:0]        rf_t2,
    output logic               st_valid,
    output logic [63:0]        st_addr,
    output logic [127:0]       st_data,
    output logic [TAG_W-1:0]   st_tag,
    output logic               wb_valid,
    output logic               wb_to_sp,
    output logic [4:0]         wb_idx,
    output logic [63:0]        wb_data,
    output logic               exc_undef,
    output logic               exc_sp_align,
    output logic               exc_align
);
    dec_t             dec;
    logic             taken;
    logic [XLEN-1:0]  acc_addr;
    logic [XLEN-1:0]  next_base;
    logic             sp_fault;
    logic             gran_fault;
    logic [2*XLEN-1:0] pdata;
    logic [TAG_W-1:0] ptag;
    logic             base_is_sp;

    result_t          nxt_r, cur_r;
    logic [TAG_W-1:0] nxt_tag, cur_tag;

    tps_decode u_dec (
        .issue_valid (issue_valid),
        .instr       (instr),
        .dec         (dec),
        .taken       (taken)
    );

    assign base_is_sp = (dec.rn == IDX_W'(SP_IDX));

    tps_agen #(.GRAN_LOG2(GRAN_LOG2)) u_agen (
        .form        (dec.form),
        .simm        (dec.simm),
        .base_is_sp  (base_is_sp),
        .gpr_base    (rf_base),
        .sp_val      (sp_val),
        .sp_align_en (sp_align_en),
        .acc_addr    (acc_addr),
        .next_base   (next_base),
        .sp_fault    (sp_fault),
        .gran_fault  (gran_fault)
    );

    tps_pack #(.TAG_W(TAG_W)) u_pack (
        .xt1        (rf_t1),
        .xt2        (rf_t2),
        .big_endian (big_endian),
        .tag_src    (acc_addr[TAG_LSB +: TAG_W]),
        .data       (pdata),
        .tag        (ptag)
    );

    assign rf_idx_base = dec.rn;
    assign rf_idx_t1   = dec.rt;
    assign rf_idx_t2   = dec.rt2;

    always_comb begin
        logic ok, do_st, do_wb;
        nxt_r   = '0;
        nxt_tag = '0;
        ok      = taken && feat_en;
        do_st   = ok && !sp_fault && !gran_fault;
        do_wb   = do_st && (dec.form != FORM_SOFF);
        nxt_r.exc_undef    = taken && !feat_en;
        nxt_r.exc_sp_align = ok && sp_fault;
        nxt_r.exc_align    = ok && !sp_fault && gran_fault;
        if (do_st) begin
            nxt_r.st_valid = 1'b1;
            nxt_r.st_addr  = acc_addr;
            nxt_r.st_data  = pdata;
            nxt_tag        = ptag;
        end
        if (do_wb) begin
            nxt_r.wb_valid = 1'b1;
            nxt_r.wb_to_sp = base_is_sp;
            nxt_r.wb_idx   = dec.rn;
            nxt_r.wb_data  = next_base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_r   <= '0;
            cur_tag <= '0;
        end else begin
            cur_r   <= nxt_r;
            cur_tag <= nxt_tag;
        end
    end

    assign st_valid     = cur_r.st_valid;
    assign st_addr      = cur_r.st_addr;
    assign st_data      = cur_r.st_data;
    assign st_tag       = cur_tag;
    assign wb_valid     = cur_r.wb_valid;
    assign wb_to_sp     = cur_r.wb_to_sp;
    assign wb_idx       = cur_r.wb_idx;
    assign wb_data      = cur_r.wb_data;
    assign exc_undef    = cur_r.exc_undef;
    assign exc_sp_align = cur_r.exc_sp_align;
    assign exc_align    = cur_r.exc_align;

endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
    parameter int GRAN_LOG2 = 4,
    parameter int TAG_LSB   = 56,
    parameter int TAG_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_valid,
    input logic             feat_en,
    input logic             st_valid,
    input logic [63:0]      st_addr,
    input logic [TAG_W-1:0] st_tag,
    input logic             wb_valid,
    input logic             wb_to_sp,
    input logic [4:0]       wb_idx,
    input logic             exc_undef,
    input logic             exc_sp_align,
    input logic             exc_align
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> !(st_valid || wb_valid || exc_undef || exc_sp_align || exc_align)); // R1

    AST_FEATURE_OFF_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !feat_en) |=> (!st_valid && !wb_valid)); // R4

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_valid, exc_undef, exc_sp_align, exc_align})); // R7

    AST_STORE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (st_addr[GRAN_LOG2-1:0] == '0)); // R7

    AST_TAG_FROM_ADDR: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (st_tag == st_addr[TAG_LSB +: TAG_W])); // R9

    AST_WB_WITH_STORE: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> st_valid); // R10

    AST_SP_WB_INDEX: assert property (@(posedge clk) disable iff (rst)
        wb_to_sp |-> (wb_valid && wb_idx == 5'd31)); // R10

    AST_PULSE: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !$past(issue_valid)) |-> 1'b0); // R11
endmodule

bind tagpair_store_unit tps_checker #(
    .GRAN_LOG2(GRAN_LOG2), .TAG_LSB(TAG_LSB), .TAG_W(TAG_W)
) u_chk (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .feat_en(feat_en),
    .st_valid(st_valid), .st_addr(st_addr), .st_tag(st_tag),
    .wb_valid(wb_valid), .wb_to_sp(wb_to_sp), .wb_idx(wb_idx),
    .exc_undef(exc_undef), .exc_sp_align(exc_sp_align), .exc_align(exc_align)
);

// File: tb/tagpair_store_unit_test.sv
`timescale 1ns/1ps
module tagpair_store_unit_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst, issue_valid, feat_en, big_endian, sp_align_en;
    logic [31:0]  instr;
    logic [63:0]  sp_val;
    logic [4:0]   rf_idx_base, rf_idx_t1, rf_idx_t2;
    logic [63:0]  rf_base, rf_t1, rf_t2;
    logic         st_valid, wb_valid, wb_to_sp, exc_undef, exc_sp_align, exc_align;
    logic [63:0]  st_addr, wb_data;
    logic [127:0] st_data;
    logic [3:0]   st_tag;
    logic [4:0]   wb_idx;

    logic [63:0] xr [32];
    assign rf_base = xr[rf_idx_base];
    assign rf_t1   = xr[rf_idx_t1];
    assign rf_t2   = xr[rf_idx_t2];

    tagpair_store_unit uut (.*);

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // expected values
    logic         e_st, e_wb, e_sp, e_un, e_spf, e_alf;
    logic [63:0]  e_addr, e_wbd;
    logic [127:0] e_data;
    logic [3:0]   e_tag;
    logic [4:0]   e_idx;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] form, input int simm,
                                      input int rt2, input int rn, input int rt);
        logic [6:0] s;
        s = 7'(simm);
        return {7'b0110100, form, 1'b0, s, 5'(rt2), 5'(rn), 5'(rt)};
    endfunction

    // behavioural reference for the current inputs
    task automatic model();
        bit     m, post, soff;
        longint base, off, acc;
        int     rn;
        m    = issue_valid && instr[31:25] == 7'b0110100 && !instr[22] && instr[24:23] != 2'b00;
        post = instr[24:23] == 2'b01;
        soff = instr[24:23] == 2'b10;
        rn   = int'(instr[9:5]);
        base = (rn == 31) ? longint'(sp_val) : longint'(xr[rn]);
        off  = longint'($signed(instr[21:15])) * 16;
        acc  = post ? base : base + off;
        e_st = 0; e_wb = 0; e_sp = 0; e_addr = 0; e_wbd = 0; e_data = 0; e_tag = 0; e_idx = 0;
        e_un  = m && !feat_en;
        e_spf = m && feat_en && rn == 31 && sp_align_en && sp_val[3:0] != 0;
        e_alf = m && feat_en && !e_spf && (acc % 16 != 0);
        if (m && feat_en && !e_spf && !e_alf) begin
            e_st   = 1;
            e_addr = 64'(acc);
            e_tag  = e_addr[59:56];
            e_data = big_endian ? {xr[instr[4:0]], xr[instr[14:10]]}
                                : {xr[instr[14:10]], xr[instr[4:0]]};
            if (!soff) begin
                e_wb  = 1;
                e_sp  = rn == 31;
                e_idx = 5'(rn);
                e_wbd = 64'(base + off);
            end
        end
    endtask

    task automatic compare(input string tagline);
        chk("R7",  {tagline, " st_valid"}, 128'(st_valid), 128'(e_st));
        chk("R6",  {tagline, " st_addr"},  128'(st_addr),  128'(e_addr));
        chk("R8",  {tagline, " st_data"},  st_data,        e_data);
        chk("R9",  {tagline, " st_tag"},   128'(st_tag),   128'(e_tag));
        chk("R10", {tagline, " wb_valid"}, 128'(wb_valid), 128'(e_wb));
        chk("R10", {tagline, " wb_to_sp"}, 128'(wb_to_sp), 128'(e_sp));
        chk("R10", {tagline, " wb_idx"},   128'(wb_idx),   128'(e_idx));
        chk("R3",  {tagline, " wb_data"},  128'(wb_data),  128'(e_wbd));
        chk("R4",  {tagline, " exc_undef"}, 128'(exc_undef), 128'(e_un));
        chk("R5",  {tagline, " exc_sp_align"}, 128'(exc_sp_align), 128'(e_spf));
        chk("R7",  {tagline, " exc_align"}, 128'(exc_align), 128'(e_alf));
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(input string tagline, input logic iv, input logic [31:0] w);
        issue_valid = iv;
        instr = w;
        #0.5;
        chk("R2", {tagline, " idx_base"}, 128'(rf_idx_base), 128'(w[9:5]));
        chk("R2", {tagline, " idx_t1"},   128'(rf_idx_t1),   128'(w[4:0]));
        chk("R2", {tagline, " idx_t2"},   128'(rf_idx_t2),   128'(w[14:10]));
        @(posedge clk);
        model();
        @(negedge clk);
        compare(tagline);
        issue_valid = 0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++)
            xr[i] = {8'h0A + 8'(i), 24'h0, 32'h1000 + 32'(i * 32'h100)};
        xr[7] = 64'h0C00_0000_0000_2008;           // misaligned base
        xr[9] = 64'h0500_0000_0000_0010;           // near tag boundary
        rst = 1; issue_valid = 0; instr = 0; feat_en = 1; big_endian = 0;
        sp_align_en = 1; sp_val = 64'h0300_0000_0000_8000;
        repeat (3) @(negedge clk);
        // R11: reset state
        e_st = 0; e_wb = 0; e_sp = 0; e_un = 0; e_spf = 0; e_alf = 0;
        e_addr = 0; e_wbd = 0; e_data = 0; e_tag = 0; e_idx = 0;
        compare("R11 reset");
        rst = 0;

        step("R6 post LE",       1, mk(2'b01,  5, 2, 3, 1));
        big_endian = 1;
        step("R6 pre BE",        1, mk(2'b11, -3, 4, 5, 6));
        step("R10 soff BE",      1, mk(2'b10,  7, 8, 2, 4));
        big_endian = 0;
        step("R5 sp pre",        1, mk(2'b11, -1, 1, 31, 2));
        step("R3 imm max",       1, mk(2'b11, 63, 3, 4, 5));
        step("R3 imm min",       1, mk(2'b01, -64, 3, 4, 5));
        step("R9 tag cross",     1, mk(2'b11, -2, 1, 9, 2));
        step("R7 gran fault",    1, mk(2'b11,  1, 1, 7, 2));
        step("R7 post misalign", 1, mk(2'b01,  1, 1, 7, 2));
        step("R6 soff fixes",    1, mk(2'b10,  0, 1, 9, 2));
        sp_val = 64'h0300_0000_0000_8004;
        step("R5 sp fault",      1, mk(2'b11,  0, 1, 31, 2));
        sp_align_en = 0;
        step("R5 sp chk off",    1, mk(2'b01,  2, 1, 31, 2));
        step("R5 sp chk off pre",1, mk(2'b11,  0, 1, 31, 2));
        sp_val = 64'h0300_0000_0000_8010;
        step("R10 sp post wb",   1, mk(2'b01,  3, 1, 31, 2));
        feat_en = 0;
        step("R4 feature off",   1, mk(2'b11,  1, 1, 3, 2));
        step("R4 over align",    1, mk(2'b11,  1, 1, 7, 2));
        feat_en = 1;
        step("R1 bit22",         1, mk(2'b11,  1, 1, 3, 2) | 32'h0040_0000);
        step("R1 form00",        1, mk(2'b00,  1, 1, 3, 2));
        step("R1 opcode",        1, mk(2'b11,  1, 1, 3, 2) ^ 32'h8000_0000);
        step("R1 no issue",      0, mk(2'b11,  1, 1, 3, 2));
        step("R11 back1",        1, mk(2'b01,  1, 10, 11, 12));
        step("R11 back2",        1, mk(2'b10, -1, 13, 14, 15));
        step("R11 idle",         0, 32'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule